// File: doc/BRIEF.md
# Multi-Channel Compare-Match Periodic Timer

This block is a bank of independent 16-bit up-counters behind a small register bus. Each channel counts ticks of its own prescaler. When its counter has reached the channel's compare value, the next tick raises a sticky match flag. If the channel is set to clear on compare, that same tick also returns the counter to zero. The period is therefore the compare value plus one prescaled ticks. Each channel raises an interrupt request while its flag is set and its enable bit is on.

Software prepares a channel by writing its configuration registers. It then sets the channel's bit in one run register that all channels share. To acknowledge a match, software must read the status register while the flag shows 1 and then write a value with bit 0 cleared. A write made without that prior read leaves the flag alone. This keeps a late or stray write from discarding an event that software has not yet seen.

Top module: `tmr_unit`

## Requirements
- R1: After a synchronous reset every channel register, the run register and `bus_rdata` read as 0, and every `irq` bit is low.
- R2: The address is {channel index, 4-bit offset}. Each channel occupies 16 bytes: control at offset 0x0, mode at 0x1, pin control at 0x2, interrupt enable at 0x4, status at 0x5, counter at 0x6 and compare at 0x8. Control, mode, pin control and enable keep only `bus_wdata[7:0]` and read back zero-extended. Counter and compare keep all 16 bits. A read issued with `bus_rd` in one cycle presents its data on `bus_rdata` after the next clock edge.
- R3: The run register is at address NUM_CH*16. Bit n lets channel n count, and bits at or above NUM_CH read as 0. A channel whose run bit is 0 holds its counter value, and its prescaler returns to zero. After a restart, a full prescale interval passes before the first tick.
- R4: Control bits [1:0] select a prescale division of 1, 4, 16 or 64, as 4 to the power of the field.
- R5: Control bits [7:5] = 001 select clear on compare. The tick that finds counter equal to compare loads 0 into the counter and sets status bit 0 at the same edge. With division d, a channel started from counter 0 sets its flag (compare+1)*d cycles after the run bit is written.
- R6: For any other value of control bits [7:5], the counter keeps incrementing past the compare value and wraps from 0xFFFF to 0. The tick that finds counter equal to compare still sets the flag.
- R7: `irq[n]` is high exactly while channel n's status bit 0 and enable bit 0 are both 1.
- R8: Status bit 0 clears only on a status write with data bit 0 = 0, and only if a status read has returned the bit as 1 since the last clear. A write of 1, or a write of 0 with no such read, leaves the flag set.
- R9: A match tick that coincides with a clearing status write leaves the flag set. The collision also consumes the earlier read, so clearing again requires a new status read.
- R10: A counter write in the same cycle as a tick loads the written value. It overrides both the increment and the compare clear.
- R11: The mode and pin-control registers are storage only. They read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | $clog2(NUM_CH+1)+4 | Register address {channel, offset} |
| bus_wdata | input | 16 | Write data; byte registers use bits [7:0] |
| bus_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| irq | output | NUM_CH | Per-channel interrupt request |

## Verification
Two collisions matter most. The first is a match tick that sets the flag at the same edge as a clearing status write. The bench places the write exactly on the fourth tick of a compare-3 period and then stops the channel. A flag that reads 1 afterwards, and survives one more unarmed clearing write, shows both that the set won and that the earlier read was consumed. The second is a counter write that lands on a compare-clear tick. It is provoked with compare 0 while the channel is running, and it is judged from the counter value read after a fixed number of further ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BUS_W = 16;
    localparam int OFF_W = 4;
    localparam int PRE_W = 6;

    typedef enum logic [OFF_W-1:0] {
        RO_CTRL = 4'h0,
        RO_MODE = 4'h1,
        RO_PINS = 4'h2,
        RO_IEN  = 4'h4,
        RO_STAT = 4'h5,
        RO_CNT  = 4'h6,
        RO_CMP  = 4'h8
    } reg_off_e;

    localparam logic [2:0] CLR_ON_CMPA = 3'b001;

    // control byte: clear source, unused middle bits, prescale select
    typedef struct packed {
        logic [2:0] clr_sel;
        logic [2:0] spare;
        logic [1:0] psel;
    } ctrl_t;

    // one channel's view of a bus cycle
    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [OFF_W-1:0] off;
        logic [BUS_W-1:0] wdata;
    } chan_req_t;

    // terminal count of the prescaler: 4**psel - 1
    function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] psel);
        logic [PRE_W:0] one_hot;
        one_hot = (PRE_W+1)'(1) << {psel, 1'b0};
        return PRE_W'(one_hot - 1'b1);
    endfunction

    function automatic logic [BUS_W-1:0] byte_ext(input logic [7:0] b);
        return {{(BUS_W-8){1'b0}}, b};
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] psel,
    output logic       tick
);

    logic [PRE_W-1:0] pcnt;

    assign tick = run && (pcnt == pre_limit(psel));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  chan_req_t        req,
    output logic [BUS_W-1:0] rdata,
    output logic             irq,
    output logic             tick,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             flag_o,
    output logic             arm_o,
    output logic             clr_en_o
);

    ctrl_t            ctrl_q;
    logic [7:0]       mode_q;
    logic [7:0]       pins_q;
    logic [7:0]       ien_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             arm_q;

    logic match, clr_en, set_ev, clr_req, rd_stat, cnt_wr;

    tmr_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .psel (ctrl_q.psel),
        .tick (tick)
    );

    always_comb begin
        match   = (cnt_q == cmp_q);
        clr_en  = (ctrl_q.clr_sel == CLR_ON_CMPA);
        set_ev  = tick && match;
        cnt_wr  = req.wr && (req.off == RO_CNT);
        rd_stat = req.rd && (req.off == RO_STAT);
        clr_req = req.wr && (req.off == RO_STAT) && !req.wdata[0] && arm_q;
    end

    // configuration storage
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
            pins_q <= '0;
            ien_q  <= '0;
            cmp_q  <= '0;
        end else if (req.wr) begin
            case (req.off)
                RO_CTRL: ctrl_q <= ctrl_t'(req.wdata[7:0]);
                RO_MODE: mode_q <= req.wdata[7:0];
                RO_PINS: pins_q <= req.wdata[7:0];
                RO_IEN:  ien_q  <= req.wdata[7:0];
                RO_CMP:  cmp_q  <= req.wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // counter: bus write first, then compare clear, then increment
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= req.wdata[CNT_W-1:0];
        end else if (tick) begin
            cnt_q <= (match && clr_en) ? '0 : cnt_q + 1'b1;
        end
    end

    // match flag with read-then-write-zero acknowledge; a new match wins
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            if (set_ev) begin
                flag_q <= 1'b1;
            end else if (clr_req) begin
                flag_q <= 1'b0;
            end
            if (clr_req) begin
                arm_q <= 1'b0;
            end else if (rd_stat && flag_q) begin
                arm_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (req.off)
            RO_CTRL: rdata = byte_ext(ctrl_q);
            RO_MODE: rdata = byte_ext(mode_q);
            RO_PINS: rdata = byte_ext(pins_q);
            RO_IEN:  rdata = byte_ext(ien_q);
            RO_STAT: rdata = byte_ext({7'b0, flag_q});
            RO_CNT:  rdata = BUS_W'(cnt_q);
            RO_CMP:  rdata = BUS_W'(cmp_q);
            default: rdata = '0;
        endcase
    end

    assign irq      = flag_q && ien_q[0];
    assign cnt_o    = cnt_q;
    assign cmp_o    = cmp_q;
    assign flag_o   = flag_q;
    assign arm_o    = arm_q;
    assign clr_en_o = clr_en;

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter  int NUM_CH = 3,
    parameter  int CNT_W  = 16,
    localparam int SEL_W  = $clog2(NUM_CH + 1),
    localparam int AW     = SEL_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] off;
    logic             run_hit;
    logic [NUM_CH-1:0] start_q;
    logic [BUS_W-1:0]  rd_next;

    logic [BUS_W-1:0]             ch_rdata [NUM_CH];
    logic [NUM_CH-1:0]            tick_v, flag_v, arm_v, clr_en_v;
    logic [NUM_CH-1:0]            cnt_wr_v, stat_zero_wr_v;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_v, cmp_v;

    assign sel     = bus_addr[AW-1:OFF_W];
    assign off     = bus_addr[OFF_W-1:0];
    assign run_hit = (sel == SEL_W'(NUM_CH)) && (off == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (bus_wr && run_hit) begin
            start_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        chan_req_t req;
        assign req.wr    = bus_wr && (sel == SEL_W'(g));
        assign req.rd    = bus_rd && (sel == SEL_W'(g));
        assign req.off   = off;
        assign req.wdata = bus_wdata;

        assign cnt_wr_v[g]       = req.wr && (off == RO_CNT);
        assign stat_zero_wr_v[g] = req.wr && (off == RO_STAT) && !bus_wdata[0];

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .run      (start_q[g]),
            .req      (req),
            .rdata    (ch_rdata[g]),
            .irq      (irq[g]),
            .tick     (tick_v[g]),
            .cnt_o    (cnt_v[g]),
            .cmp_o    (cmp_v[g]),
            .flag_o   (flag_v[g]),
            .arm_o    (arm_v[g]),
            .clr_en_o (clr_en_v[g])
        );
    end

    always_comb begin
        rd_next = '0;
        if (run_hit) begin
            rd_next = BUS_W'(start_q);
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel == SEL_W'(i)) begin
                rd_next = ch_rdata[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_CH-1:0]            start_q,
    input logic [NUM_CH-1:0]            tick_v,
    input logic [NUM_CH-1:0]            flag_v,
    input logic [NUM_CH-1:0]            arm_v,
    input logic [NUM_CH-1:0]            clr_en_v,
    input logic [NUM_CH-1:0]            cnt_wr_v,
    input logic [NUM_CH-1:0]            stat_zero_wr_v,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_v,
    input logic [NUM_CH-1:0][CNT_W-1:0] cmp_v,
    input logic [BUS_W-1:0]             bus_wdata
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R3: a halted channel never sees a prescaler tick
        p_no_tick_halted_r3: assert property (@(posedge clk) disable iff (rst)
            !start_q[i] |-> !tick_v[i]);

        // R3: a halted channel keeps its counter unless software writes it
        p_halt_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (!start_q[i] && !cnt_wr_v[i]) |=> $stable(cnt_v[i]));

        // R5: a clearing match tick returns the counter to zero
        p_match_clear_r5: assert property (@(posedge clk) disable iff (rst)
            (tick_v[i] && (cnt_v[i] == cmp_v[i]) && clr_en_v[i] && !cnt_wr_v[i])
            |=> (cnt_v[i] == '0));

        // R6: any other tick advances the counter by one, wrapping
        p_step_r6: assert property (@(posedge clk) disable iff (rst)
            (tick_v[i] && !cnt_wr_v[i] && !((cnt_v[i] == cmp_v[i]) && clr_en_v[i]))
            |=> (cnt_v[i] == CNT_W'($past(cnt_v[i]) + 1'b1)));

        // R8: the flag only falls on a zero write to status
        p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
            (flag_v[i] && !stat_zero_wr_v[i]) |=> flag_v[i]);

        // R8: without a prior read the flag cannot fall
        p_unarmed_keep_r8: assert property (@(posedge clk) disable iff (rst)
            (flag_v[i] && !arm_v[i]) |=> flag_v[i]);

        // R9: a match tick always leaves the flag set
        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
            (tick_v[i] && (cnt_v[i] == cmp_v[i])) |=> flag_v[i]);

        // R10: a counter write loads the written value
        p_write_prio_r10: assert property (@(posedge clk) disable iff (rst)
            cnt_wr_v[i] |=> (cnt_v[i] == $past(bus_wdata[CNT_W-1:0])));
    end

endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .start_q        (start_q),
    .tick_v         (tick_v),
    .flag_v         (flag_v),
    .arm_v          (arm_v),
    .clr_en_v       (clr_en_v),
    .cnt_wr_v       (cnt_wr_v),
    .stat_zero_wr_v (stat_zero_wr_v),
    .cnt_v          (cnt_v),
    .cmp_v          (cmp_v),
    .bus_wdata      (bus_wdata)
);

// File: tb/tmr_unit_bench.sv
`timescale 1ns/1ps
module tmr_unit_bench;

    localparam int NUM_CH = 3;
    localparam logic [5:0] RUN_A = 6'h30;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [5:0]        bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic [NUM_CH-1:0] irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic        rd_d = 1'b0;

    always #2 clk = ~clk;

    tmr_unit #(.NUM_CH(NUM_CH), .CNT_W(16)) u_tmr_unit (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [5:0] ra(input int ch, input logic [3:0] off);
        return {ch[1:0], off};
    endfunction

    // monitor: compares read data against the scoreboard queue
    always @(posedge clk) rd_d <= bus_rd;

    always @(negedge clk) begin
        if (rd_d) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] e, input string tag);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // cycles from the run write until irq[ch] is high
    task automatic measure(input int ch, input int exp, input string tag);
        int n = 0;
        while (n < 2000) begin
            @(posedge clk); #1;
            n++;
            if (irq[ch]) break;
        end
        chk(16'(n), 16'(exp), tag);
    endtask

    task automatic ack0(input string tag);
        rd(ra(0, 4'h5), 16'h0001, tag);
        wr(ra(0, 4'h5), 16'h00FE);
        rd(ra(0, 4'h5), 16'h0000, tag);
    endtask

    task automatic run_period(input logic [7:0] ctl, input logic [15:0] cmpv,
                              input int exp, input string tag);
        wr(ra(0, 4'h0), {8'h00, ctl});
        wr(ra(0, 4'h8), cmpv);
        wr(ra(0, 4'h6), 16'h0000);
        wr(RUN_A, 16'h0001);
        measure(0, exp, tag);
        wr(RUN_A, 16'h0000);
        ack0(tag);
    endtask

    initial begin
        idle(4);
        #1 rst = 1'b0;

        // R1: reset state
        chk(16'(irq), 16'h0000, "R1 irq");
        rd(ra(0, 4'h0), 16'h0000, "R1 ctrl");
        rd(ra(0, 4'h6), 16'h0000, "R1 cnt");
        rd(ra(0, 4'h8), 16'h0000, "R1 cmp");
        rd(ra(0, 4'h5), 16'h0000, "R1 stat");
        rd(RUN_A, 16'h0000, "R1 run");

        // R2 and R11: byte lanes and storage
        wr(ra(1, 4'h0), 16'hABCD);
        rd(ra(1, 4'h0), 16'h00CD, "R2 ctrl byte");
        wr(ra(1, 4'h8), 16'h1234);
        rd(ra(1, 4'h8), 16'h1234, "R2 cmp word");
        wr(ra(1, 4'h6), 16'hBEEF);
        rd(ra(1, 4'h6), 16'hBEEF, "R2 cnt word");
        wr(ra(1, 4'h1), 16'hFF5A);
        rd(ra(1, 4'h1), 16'h005A, "R11 mode");
        wr(ra(1, 4'h2), 16'h773C);
        rd(ra(1, 4'h2), 16'h003C, "R11 pins");

        // R4 and R5: periods for each prescale setting
        wr(ra(0, 4'h4), 16'h0001);
        run_period(8'h20, 16'd4, 5,   "R5 div1 period");
        run_period(8'h21, 16'd2, 12,  "R4 div4 period");
        run_period(8'h22, 16'd3, 64,  "R4 div16 period");
        run_period(8'h23, 16'd1, 128, "R4 div64 period");

        // R6: no clear, wrap through zero, flag still set on match
        wr(ra(0, 4'h0), 16'h0000);
        wr(ra(0, 4'h8), 16'h0001);
        wr(ra(0, 4'h6), 16'hFFFE);
        wr(RUN_A, 16'h0001);
        idle(2);
        wr(RUN_A, 16'h0000);
        rd(ra(0, 4'h6), 16'h0002, "R6 wrap count");
        ack0("R6 flag");

        // R3: halted hold, independent channels
        idle(10);
        rd(ra(0, 4'h6), 16'h0002, "R3 hold");
        wr(ra(1, 4'h0), 16'h0020);
        wr(ra(1, 4'h8), 16'h00FF);
        wr(ra(1, 4'h6), 16'h0000);
        wr(RUN_A, 16'h0002);
        rd(RUN_A, 16'h0002, "R3 run readback");
        idle(3);
        wr(RUN_A, 16'h0000);
        rd(ra(0, 4'h6), 16'h0002, "R3 ch0 idle");
        rd(ra(1, 4'h6), 16'h0007, "R3 ch1 count");

        // R3: prescaler restarts from zero
        wr(ra(0, 4'h0), 16'h0021);
        wr(ra(0, 4'h8), 16'h0000);
        wr(ra(0, 4'h6), 16'h0000);
        wr(RUN_A, 16'h0001);
        wr(RUN_A, 16'h0000);
        wr(RUN_A, 16'h0001);
        measure(0, 4, "R3 prescaler restart");
        wr(RUN_A, 16'h0000);
        ack0("R3 ack");

        // R8: clear protocol
        wr(ra(0, 4'h0), 16'h0020);
        wr(ra(0, 4'h6), 16'h0000);
        wr(RUN_A, 16'h0001);
        wr(RUN_A, 16'h0000);
        wr(ra(0, 4'h5), 16'h00FE);
        rd(ra(0, 4'h5), 16'h0001, "R8 unarmed zero write");
        wr(ra(0, 4'h5), 16'h0001);
        rd(ra(0, 4'h5), 16'h0001, "R8 one write");
        wr(ra(0, 4'h5), 16'h00FE);
        rd(ra(0, 4'h5), 16'h0000, "R8 armed clear");
        chk(16'(irq[0]), 16'h0000, "R8 irq low");

        // R7: irq gated by enable
        wr(RUN_A, 16'h0001);
        wr(RUN_A, 16'h0000);
        wr(ra(0, 4'h4), 16'h0000);
        chk(16'(irq[0]), 16'h0000, "R7 disabled");
        wr(ra(0, 4'h4), 16'h0001);
        chk(16'(irq[0]), 16'h0001, "R7 enabled");
        ack0("R7 ack");
        chk(16'(irq[0]), 16'h0000, "R7 cleared");

        // R9: match tick and clearing write at the same edge
        wr(ra(0, 4'h8), 16'h0003);
        wr(ra(0, 4'h6), 16'h0000);
        wr(RUN_A, 16'h0001);
        idle(3);
        rd(ra(0, 4'h5), 16'h0001, "R9 arm read");
        idle(1);
        wr(ra(0, 4'h5), 16'h00FE);
        wr(RUN_A, 16'h0000);
        wr(ra(0, 4'h5), 16'h00FE);
        rd(ra(0, 4'h5), 16'h0001, "R9 set wins");
        chk(16'(irq[0]), 16'h0001, "R9 irq held");
        ack0("R9 ack");

        // R10: counter write beats compare clear and increment
        wr(ra(0, 4'h8), 16'h0000);
        wr(ra(0, 4'h6), 16'h0000);
        wr(RUN_A, 16'h0001);
        wr(ra(0, 4'h6), 16'h0050);
        wr(RUN_A, 16'h0000);
        rd(ra(0, 4'h6), 16'h0052, "R10 write priority");

        idle(4);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule